// File: doc/BRIEF.md
# DRAM Command Request Chooser

This block picks one request out of a set of per-bank command request streams inside a DRAM controller's multiplexer. Each request lane carries a valid flag, read and write type flags, an address field and a bank field. In return it gets a ready strobe. Two control inputs say whether the controller currently wants reads, writes or both. Only lanes that are valid and whose type matches one of the asserted wishes can be chosen.

A registered grant pointer names the current choice. The command output shows that lane's address, bank and type flags through a multiplexer, and the output valid is the chosen lane's eligibility. When the choice is not eligible, or when it is accepted downstream, the pointer moves on one clock edge later. It moves to the next eligible lane in rotating order, so every requester gets served in turn. Two helper outputs tell the controller whether the current choice counts as a write or as a read.

Top module: `dram_cmd_chooser`

## Requirements
- R1: Reset clears the grant pointer to lane 0. While reset is held, if lane 0 is eligible, the command output shows lane 0's fields with valid high.
- R2: A lane whose valid input is low is never presented with valid high, even when its read or write flag is set.
- R3: With only the write wish asserted, a high command valid always comes with the write flag of the chosen request set.
- R4: With only the read wish asserted, a high command valid always comes with the read flag of the chosen request set.
- R5: With both wishes asserted, lanes of either type are eligible.
- R6: With neither wish asserted, command valid, all lane ready strobes and both helper outputs are low.
- R7: If the current choice is not eligible and another lane is, the new lane's address and bank appear on the command output after exactly one clock edge. Between edges the command fields follow the granted lane's inputs.
- R8: The search order is ascending lane index, wrapping from the last lane to lane 0, and starts at the lane after the current grant. On an accepted command (valid and ready both high) the grant moves to the first eligible lane in that order. A lone eligible lane is granted again.
- R9: While command valid is high and command ready is low, the grant does not change.
- R10: Lane ready bit i is high only when lane i is granted, command valid is high and command ready is high. At most one ready bit is high at a time.
- R11: The write helper equals command valid AND write wish AND the chosen write flag. The read helper equals command valid AND read wish AND the chosen read flag.
- R12: Command valid is low whenever no lane is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| want_rd_i | input | 1 | Controller accepts read requests |
| want_wr_i | input | 1 | Controller accepts write requests |
| req_valid_i | input | N_REQ | Per-lane request valid |
| req_is_rd_i | input | N_REQ | Per-lane read flag |
| req_is_wr_i | input | N_REQ | Per-lane write flag |
| req_addr_i | input | N_REQ*ADDR_W | Per-lane address, lane i at bits [i*ADDR_W +: ADDR_W] |
| req_bank_i | input | N_REQ*BANK_W | Per-lane bank, lane i at bits [i*BANK_W +: BANK_W] |
| req_ready_o | output | N_REQ | Per-lane ready strobe |
| cmd_valid_o | output | 1 | Chosen command is eligible |
| cmd_ready_i | input | 1 | Downstream accepts the command |
| cmd_addr_o | output | ADDR_W | Chosen address |
| cmd_bank_o | output | BANK_W | Chosen bank |
| cmd_is_rd_o | output | 1 | Chosen read flag |
| cmd_is_wr_o | output | 1 | Chosen write flag |
| pick_is_rd_o | output | 1 | Current choice counts as a read |
| pick_is_wr_o | output | 1 | Current choice counts as a write |

## Verification
The grant pointer is the only register, so a change of grant shows on the outputs one clock edge after the stimulus that causes it. Valid, fields, ready strobes and helpers follow the inputs for the held grant with no delay at all. The bench changes inputs on the falling edge and samples half a nanosecond before the next rising edge. Each sample therefore sees the grant from the last rising edge combined with the new inputs. A behavioural pointer model advances on the same rising edge and is compared against every output at that sample point. Directed sequences also check the exact lane expected in each cycle.

// File: rtl/dram_cmd_chooser_pkg.sv
package dram_cmd_chooser_pkg;

  // Width of a lane index for a given lane count (at least one bit).
  function automatic int idx_width(int lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction

endpackage

// File: rtl/dcc_eligible.sv
module dcc_eligible #(
  parameter int N_REQ = 8
) (
  input  logic [N_REQ-1:0] valid_i,
  input  logic [N_REQ-1:0] is_rd_i,
  input  logic [N_REQ-1:0] is_wr_i,
  input  logic             want_rd_i,
  input  logic             want_wr_i,
  output logic [N_REQ-1:0] elig_o
);

  // A lane may compete when it is valid and its type matches a wish.
  for (genvar g = 0; g < N_REQ; g++) begin : g_lane
    assign elig_o[g] = valid_i[g] & ((is_rd_i[g] & want_rd_i) | (is_wr_i[g] & want_wr_i));
  end

endmodule

// File: rtl/dcc_rr_pointer.sv
module dcc_rr_pointer #(
  parameter int N_REQ = 8,
  parameter int GW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] elig_i,
  input  logic             cmd_ready_i,
  output logic [GW-1:0]    grant_o,
  output logic             cur_valid_o
);

  logic [GW-1:0] grant_q;
  logic [GW-1:0] grant_d;
  logic [GW-1:0] pick_d;
  logic          found_d;
  logic          adv_en;

  assign cur_valid_o = elig_i[grant_q];
  assign grant_o     = grant_q;

  // Rotating search: lane after the grant first, the grant itself last.
  always_comb begin
    logic [GW-1:0] idx_v;
    found_d = 1'b0;
    pick_d  = grant_q;
    idx_v   = '0;
    for (int k = 1; k <= N_REQ; k++) begin
      idx_v = GW'((int'(grant_q) + k) % N_REQ);
      if (!found_d && elig_i[idx_v]) begin
        found_d = 1'b1;
        pick_d  = idx_v;
      end
    end
  end

  // Clock enable: move when the choice is idle or has just been taken.
  assign adv_en = found_d & (cmd_ready_i | ~cur_valid_o);

  always_comb begin
    grant_d = grant_q;
    if (adv_en) grant_d = pick_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= '0;
    else        grant_q <= grant_d;
  end

  // R9: a stalled command keeps its grant.
  p_hold_on_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_valid_o && !cmd_ready_i) |=> $stable(grant_q));

  // R8: an accepted command with a rival eligible lane moves the grant.
  p_rotate_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_valid_o && cmd_ready_i && ($countones(elig_i) > 1)) |=> (grant_q != $past(grant_q)));

endmodule

// File: rtl/dcc_field_mux.sv
module dcc_field_mux #(
  parameter int N_REQ  = 8,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3,
  parameter int GW     = 3
) (
  input  logic [GW-1:0]           grant_i,
  input  logic [N_REQ*ADDR_W-1:0] addr_i,
  input  logic [N_REQ*BANK_W-1:0] bank_i,
  input  logic [N_REQ-1:0]        is_rd_i,
  input  logic [N_REQ-1:0]        is_wr_i,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [BANK_W-1:0]       bank_o,
  output logic                    is_rd_o,
  output logic                    is_wr_o
);

  always_comb begin
    addr_o  = addr_i[int'(grant_i)*ADDR_W +: ADDR_W];
    bank_o  = bank_i[int'(grant_i)*BANK_W +: BANK_W];
    is_rd_o = is_rd_i[grant_i];
    is_wr_o = is_wr_i[grant_i];
  end

endmodule

// File: rtl/dram_cmd_chooser.sv
module dram_cmd_chooser
  import dram_cmd_chooser_pkg::*;
#(
  parameter int N_REQ  = 8,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    want_rd_i,
  input  logic                    want_wr_i,
  input  logic [N_REQ-1:0]        req_valid_i,
  input  logic [N_REQ-1:0]        req_is_rd_i,
  input  logic [N_REQ-1:0]        req_is_wr_i,
  input  logic [N_REQ*ADDR_W-1:0] req_addr_i,
  input  logic [N_REQ*BANK_W-1:0] req_bank_i,
  output logic [N_REQ-1:0]        req_ready_o,
  output logic                    cmd_valid_o,
  input  logic                    cmd_ready_i,
  output logic [ADDR_W-1:0]       cmd_addr_o,
  output logic [BANK_W-1:0]       cmd_bank_o,
  output logic                    cmd_is_rd_o,
  output logic                    cmd_is_wr_o,
  output logic                    pick_is_rd_o,
  output logic                    pick_is_wr_o
);

  localparam int GW = idx_width(N_REQ);

  logic [N_REQ-1:0] elig;
  logic [GW-1:0]    grant;
  logic             cur_valid;

  dcc_eligible #(.N_REQ(N_REQ)) u_elig (
    .valid_i   (req_valid_i),
    .is_rd_i   (req_is_rd_i),
    .is_wr_i   (req_is_wr_i),
    .want_rd_i (want_rd_i),
    .want_wr_i (want_wr_i),
    .elig_o    (elig)
  );

  dcc_rr_pointer #(.N_REQ(N_REQ), .GW(GW)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .elig_i      (elig),
    .cmd_ready_i (cmd_ready_i),
    .grant_o     (grant),
    .cur_valid_o (cur_valid)
  );

  dcc_field_mux #(.N_REQ(N_REQ), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .GW(GW)) u_mux (
    .grant_i (grant),
    .addr_i  (req_addr_i),
    .bank_i  (req_bank_i),
    .is_rd_i (req_is_rd_i),
    .is_wr_i (req_is_wr_i),
    .addr_o  (cmd_addr_o),
    .bank_o  (cmd_bank_o),
    .is_rd_o (cmd_is_rd_o),
    .is_wr_o (cmd_is_wr_o)
  );

  assign cmd_valid_o = cur_valid;

  // Ready goes back only to the granted lane during a handshake.
  for (genvar g = 0; g < N_REQ; g++) begin : g_ready
    assign req_ready_o[g] = cmd_ready_i & cur_valid & (grant == GW'(g));
  end

  assign pick_is_wr_o = cur_valid & want_wr_i & cmd_is_wr_o;
  assign pick_is_rd_o = cur_valid & want_rd_i & cmd_is_rd_o;

  // R2: a presented command always comes from a valid lane.
  p_from_valid_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> req_valid_i[grant]);

  // R3: write-only mode presents writes only.
  p_write_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && want_wr_i && !want_rd_i) |-> cmd_is_wr_o);

  // R4: read-only mode presents reads only.
  p_read_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && want_rd_i && !want_wr_i) |-> cmd_is_rd_o);

  // R6: with no wish, nothing is offered.
  p_no_wish_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!want_rd_i && !want_wr_i) |-> (!cmd_valid_o && (req_ready_o == '0)));

  // R10: at most one lane ready, and only during a handshake.
  p_ready_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready_o));
  p_ready_needs_hs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready_o != '0) |-> (cmd_ready_i && cmd_valid_o));

endmodule

// File: tb/test_dram_cmd_chooser.sv
`timescale 1ns/1ps
module test_dram_cmd_chooser;

  localparam int N  = 8;
  localparam int AW = 14;
  localparam int BW = 3;

  logic          clk;
  logic          rst_n;
  logic          want_rd, want_wr, cmd_ready;
  logic [N-1:0]  v, rd, wr;
  logic [N*AW-1:0] addr_flat;
  logic [N*BW-1:0] bank_flat;
  logic [N-1:0]  ready_o;
  logic          cmd_valid, cmd_is_rd, cmd_is_wr, pick_rd, pick_wr;
  logic [AW-1:0] cmd_addr;
  logic [BW-1:0] cmd_bank;

  int checks = 0;
  int failures = 0;
  int m_g;
  bit cmp_on = 0;
  bit done = 0;

  dram_cmd_chooser #(.N_REQ(N), .ADDR_W(AW), .BANK_W(BW)) i_dram_cmd_chooser (
    .clk(clk), .rst_n(rst_n), .want_rd_i(want_rd), .want_wr_i(want_wr),
    .req_valid_i(v), .req_is_rd_i(rd), .req_is_wr_i(wr),
    .req_addr_i(addr_flat), .req_bank_i(bank_flat), .req_ready_o(ready_o),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_addr_o(cmd_addr),
    .cmd_bank_o(cmd_bank), .cmd_is_rd_o(cmd_is_rd), .cmd_is_wr_o(cmd_is_wr),
    .pick_is_rd_o(pick_rd), .pick_is_wr_o(pick_wr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int a_of(int i); return (i * 37 + 5) % (1 << AW); endfunction
  function automatic int b_of(int i); return (7 - i) & 7; endfunction

  initial begin
    for (int i = 0; i < N; i++) begin
      addr_flat[i*AW +: AW] = AW'(a_of(i));
      bank_flat[i*BW +: BW] = BW'(b_of(i));
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic bit m_elig(int i);
    return v[i] && ((rd[i] && want_rd) || (wr[i] && want_wr));
  endfunction

  // Behavioural pointer model.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_g <= 0;
    else if (!m_elig(m_g) || cmd_ready) begin
      int nxt;
      bit hit;
      nxt = m_g;
      hit = 0;
      for (int k = 1; k <= N; k++) begin
        if (!hit && m_elig((m_g + k) % N)) begin
          hit = 1;
          nxt = (m_g + k) % N;
        end
      end
      m_g <= nxt;
    end
  end

  // Per-cycle comparison, half a nanosecond before the rising edge.
  always begin
    @(negedge clk);
    #2;
    if (cmp_on) begin
      bit ev;
      ev = m_elig(m_g);
      chk("R12 cmd_valid", int'(cmd_valid), int'(ev));
      chk("R7 cmd_addr", int'(cmd_addr), a_of(m_g));
      chk("R7 cmd_bank", int'(cmd_bank), b_of(m_g));
      chk("R10 req_ready", int'(ready_o), (ev && cmd_ready) ? (1 << m_g) : 0);
      chk("R11 pick_wr", int'(pick_wr), int'(ev && want_wr && wr[m_g]));
      chk("R11 pick_rd", int'(pick_rd), int'(ev && want_rd && rd[m_g]));
    end
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic expect_lane(string tag, int lane);
    chk({tag, " valid"}, int'(cmd_valid), 1);
    chk({tag, " addr"}, int'(cmd_addr), a_of(lane));
    chk({tag, " bank"}, int'(cmd_bank), b_of(lane));
  endtask

  initial begin
    rst_n = 1'b1; want_rd = 0; want_wr = 0; cmd_ready = 0;
    v = '0; rd = '0; wr = '0;
    #1 rst_n = 1'b0;
    // R1: reset state shows lane 0
    cyc(); v[0] = 1; wr[0] = 1; want_wr = 1;
    #2 expect_lane("R1", 0);
    cyc(); rst_n = 1'b1; cmp_on = 1;
    // R2 R3 R7: only valid writes compete
    cyc(); v = '0; wr = '0; rd = '0;
    v[3] = 1; rd[3] = 1; rd[4] = 1; v[5] = 1; wr[5] = 1; wr[6] = 1;
    #2 chk("R7 before edge valid", int'(cmd_valid), 0);
    cyc(); #2 expect_lane("R3", 5); chk("R3 is_wr", int'(cmd_is_wr), 1);
    // R4: switch to reads
    cyc(); want_wr = 0; want_rd = 1;
    #2 chk("R4 before edge valid", int'(cmd_valid), 0);
    cyc(); #2 expect_lane("R4", 3); chk("R4 is_rd", int'(cmd_is_rd), 1);
    // R8: rotation 6,1,2,6 with ready high
    cyc(); want_rd = 0; want_wr = 1; cmd_ready = 1;
    v = '0; rd = '0; wr = '0; v[1] = 1; v[2] = 1; v[6] = 1; wr[1] = 1; wr[2] = 1; wr[6] = 1;
    #2 chk("R8 idle valid", int'(cmd_valid), 0);
    cyc(); #2 expect_lane("R8 first", 6);
    cyc(); #2 expect_lane("R8 wrap", 1);
    cyc(); #2 expect_lane("R8 next", 2);
    // R9: stall holds
    cyc(); cmd_ready = 0;
    #2 expect_lane("R8 again", 6); chk("R10 no ready on stall", int'(ready_o), 0);
    cyc(); #2 expect_lane("R9 hold1", 6);
    cyc(); cmd_ready = 1;
    #2 expect_lane("R9 hold2", 6); chk("R10 ready lane6", int'(ready_o), 8'h40);
    cyc(); #2 expect_lane("R8 after stall", 1);
    // R8: lone eligible lane stays granted
    cyc(); v = '0; wr = '0; v[4] = 1; wr[4] = 1;
    #2 chk("R8 lone idle", int'(cmd_valid), 0);
    cyc(); #2 expect_lane("R8 lone1", 4);
    cyc(); #2 expect_lane("R8 lone2", 4);
    // R5 R11: both wishes
    cyc(); cmd_ready = 0; v = '0; wr = '0; rd = '0;
    v[2] = 1; rd[2] = 1; v[3] = 1; wr[3] = 1; want_rd = 1; want_wr = 1;
    #2 chk("R5 idle valid", int'(cmd_valid), 0);
    cyc(); cmd_ready = 1;
    #2 expect_lane("R5 read", 2);
    chk("R11 rd helper", int'(pick_rd), 1); chk("R11 wr helper", int'(pick_wr), 0);
    cyc(); cmd_ready = 0;
    #2 expect_lane("R5 write", 3);
    chk("R11 wr helper", int'(pick_wr), 1); chk("R11 rd helper", int'(pick_rd), 0);
    // R6: no wish
    cyc(); want_rd = 0; want_wr = 0; cmd_ready = 1;
    #2 chk("R6 valid", int'(cmd_valid), 0); chk("R6 ready", int'(ready_o), 0);
    chk("R6 helpers", int'({pick_rd, pick_wr}), 0);
    // R12: nothing valid
    cyc(); want_rd = 1; want_wr = 1; v = '0; rd = '1; wr = '1;
    #2 chk("R12 none valid", int'(cmd_valid), 0);
    // mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      cyc();
      v = N'($urandom); rd = N'($urandom); wr = N'($urandom);
      want_rd = 1'($urandom); want_wr = 1'($urandom); cmd_ready = 1'($urandom);
    end
    cyc();
    finish_run();
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule